// File: doc/BRIEF.md
# Banked Scratch RAM with Register Windows and Upward Stack

This block is the 128-byte on-chip data store of a small accumulator processor. Eight working registers are a movable window of eight bytes in this RAM, and a two-bit bank field picks the window. A sixteen-byte region is also reachable one bit at a time, and a byte stack grows upward through the same RAM from a pointer that starts just above the first register window.

Each cycle the core issues at most one operation. It may reach a register by number, a byte by direct address, a byte through a pointer register, a single bit, or the stack through push and pop. All results are registered and appear one cycle after the operation. An indirect or stack access that would leave the 128-byte space raises a one-cycle error pulse and changes nothing.

Top module: `bank_ram`

## Requirements
- R1: After reset the stack pointer `sp_o` is 0x07, every RAM byte reads as zero, and `rd_data_o`, `rd_bit_o` and `err_o` are 0.
- R2: Operation code 1 (register) reaches register number `reg_sel_i` in bank `bank_i`, which is byte `bank_i*8 + reg_sel_i`. Bank 0 covers 0x00–0x07 and bank 3 covers 0x18–0x1F.
- R3: Operation code 2 (direct) reaches byte `addr_i` in the range 0x00–0x7F. Direct byte n for n below 8 is register n of bank 0.
- R4: Operation code 3 (indirect) uses as its address the byte held in register 0 (`ptr_sel_i`=0) or register 1 (`ptr_sel_i`=1) of the current bank.
- R5: Operation code 4 (bit) with `we_i`=0 returns on `rd_bit_o` bit `addr_i & 7` of byte `0x20 + (addr_i >> 3)`. Bit address 0x05 is bit 5 of byte 0x20.
- R6: A bit operation with `we_i`=1 stores `bit_val_i` into that bit and leaves the other seven bits of the byte unchanged.
- R7: Operation code 5 (push) adds one to the stack pointer first and then writes `wr_data_i` at the new pointer. Three pushes from reset fill 0x08, 0x09 and 0x0A.
- R8: Operation code 6 (pop) returns the byte at the stack pointer and then subtracts one from the pointer.
- R9: An indirect address above 0x7F, a push whose new pointer is above 0x7F, or a pop with a pointer above 0x7F sets `err_o` for one cycle. Such an access writes no byte, leaves `sp_o` unchanged and returns 0 on `rd_data_o`. Every other operation clears `err_o`.
- R10: `rd_data_o` gives, one cycle after a register, direct, indirect or pop operation, the byte's value from before any write by that operation. Push, bit and no-op (code 0) operations leave `rd_data_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_i | input | 3 | Operation code (0 none, 1 register, 2 direct, 3 indirect, 4 bit, 5 push, 6 pop) |
| we_i | input | 1 | Write enable for register, direct, indirect and bit operations |
| bank_i | input | 2 | Register bank select |
| reg_sel_i | input | 3 | Register number |
| addr_i | input | 7 | Direct byte address or bit address |
| ptr_sel_i | input | 1 | Pointer register select (register 0 or 1) |
| wr_data_i | input | 8 | Write or push data |
| bit_val_i | input | 1 | Bit value to store |
| rd_data_o | output | 8 | Registered read data |
| rd_bit_o | output | 1 | Registered bit read |
| err_o | output | 1 | One-cycle out-of-range error |
| sp_o | output | 8 | Stack pointer |

## Verification
On every cycle the assertions check the stack-pointer steps for push and pop. They also check that an out-of-range stack access freezes the pointer and raises the error, that operations which cannot fail never raise it, and that a register write lands on the byte its bank picks. Only the bench scenarios can show aliasing: the same byte seen through register, direct, indirect and bit views. The bench scenarios also cover read-before-write data, bit writes leaving the neighbouring bits alone, the exact stack contents after a sequence of pushes, and a blocked indirect write leaving its aliased byte untouched.

// File: rtl/bank_ram.sv
module bank_ram (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] op_i,
  input  logic       we_i,
  input  logic [1:0] bank_i,
  input  logic [2:0] reg_sel_i,
  input  logic [6:0] addr_i,
  input  logic       ptr_sel_i,
  input  logic [7:0] wr_data_i,
  input  logic       bit_val_i,
  output logic [7:0] rd_data_o,
  output logic       rd_bit_o,
  output logic       err_o,
  output logic [7:0] sp_o
);
  localparam int          DEPTH   = 128;
  localparam int          AW      = $clog2(DEPTH);
  localparam logic [7:0]  SP_INIT = 8'h07;
  localparam logic [2:0]  OP_NOP = 3'd0, OP_REG = 3'd1, OP_DIR = 3'd2,
                          OP_IND = 3'd3, OP_BIT = 3'd4, OP_PUSH = 3'd5,
                          OP_POP = 3'd6;

  logic [7:0] mem [DEPTH];

  logic [AW-1:0] reg_addr, ptr_loc, bit_byte, acc_addr;
  logic [7:0]    ptr_val, sp_inc, old_byte, wdat;
  logic [2:0]    bit_idx;
  logic          bad, wr, rd_upd;

  assign reg_addr = {2'b00, bank_i, reg_sel_i};
  assign ptr_loc  = {2'b00, bank_i, 2'b00, ptr_sel_i};
  assign ptr_val  = mem[ptr_loc];
  assign bit_byte = {3'b010, addr_i[6:3]};
  assign bit_idx  = addr_i[2:0];
  assign sp_inc   = sp_o + 8'd1;
  assign old_byte = mem[acc_addr];

  always_comb begin
    acc_addr = '0;
    bad      = 1'b0;
    wr       = 1'b0;
    rd_upd   = 1'b0;
    wdat     = wr_data_i;
    case (op_i)
      OP_REG: begin acc_addr = reg_addr; wr = we_i; rd_upd = 1'b1; end
      OP_DIR: begin acc_addr = addr_i;   wr = we_i; rd_upd = 1'b1; end
      OP_IND: begin
        acc_addr = ptr_val[AW-1:0];
        bad      = ptr_val[7];
        wr       = we_i & ~bad;
        rd_upd   = 1'b1;
      end
      OP_BIT: begin
        acc_addr = bit_byte;
        wr       = we_i;
        wdat     = old_byte;
        wdat[bit_idx] = bit_val_i;
      end
      OP_PUSH: begin
        acc_addr = sp_inc[AW-1:0];
        bad      = sp_inc[7];
        wr       = ~bad;
      end
      OP_POP: begin
        acc_addr = sp_o[AW-1:0];
        bad      = sp_o[7];
        rd_upd   = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr) begin
      mem[acc_addr] <= wdat;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp_o      <= SP_INIT;
      rd_data_o <= '0;
      rd_bit_o  <= 1'b0;
      err_o     <= 1'b0;
    end else begin
      err_o <= bad;
      if (rd_upd) rd_data_o <= bad ? 8'h00 : old_byte;
      if (op_i == OP_BIT) rd_bit_o <= old_byte[bit_idx];
      if (op_i == OP_PUSH && !bad) sp_o <= sp_inc;
      if (op_i == OP_POP  && !bad) sp_o <= sp_o - 8'd1;
    end
  end

  p_push_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_PUSH && sp_o < 8'h7F) |=> (sp_o == $past(sp_o) + 8'd1));

  p_pop_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_POP && sp_o < 8'h80) |=> (sp_o == $past(sp_o) - 8'd1));

  p_stack_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_PUSH && sp_o >= 8'h7F && sp_o != 8'hFF) |=> (err_o && $stable(sp_o)));

  p_no_false_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_NOP || op_i == OP_REG || op_i == OP_DIR || op_i == OP_BIT) |=> !err_o);

  p_bank_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_REG && we_i) |=> (mem[$past(reg_addr)] == $past(wr_data_i)));
endmodule

// File: tb/bank_ram_test.sv
module bank_ram_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] op_i;
  logic       we_i;
  logic [1:0] bank_i;
  logic [2:0] reg_sel_i;
  logic [6:0] addr_i;
  logic       ptr_sel_i;
  logic [7:0] wr_data_i;
  logic       bit_val_i;
  logic [7:0] rd_data_o;
  logic       rd_bit_o;
  logic       err_o;
  logic [7:0] sp_o;

  always #2 clk = ~clk;

  bank_ram uut (.*);

  int tests = 0, fails = 0;
  logic [7:0] m [128];
  logic [7:0] e_sp, e_rd;
  logic       e_bit, e_err;

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] bit_byte(input logic [6:0] b);
    return 8'h20 + {4'd0, b[6:3]};
  endfunction

  task automatic model(input logic [2:0] op, input logic we, input logic [1:0] bk,
                       input logic [2:0] rs, input logic [6:0] ad, input logic ps,
                       input logic [7:0] wd, input logic bv);
    logic [7:0] a, p, n;
    e_err = 1'b0;
    case (op)
      3'd1: begin a = {3'd0, bk, rs}; e_rd = m[a[6:0]]; if (we) m[a[6:0]] = wd; end
      3'd2: begin e_rd = m[ad]; if (we) m[ad] = wd; end
      3'd3: begin
        p = m[{2'd0, bk, 2'd0, ps}];
        if (p > 8'h7F) begin e_err = 1'b1; e_rd = 8'h00; end
        else begin e_rd = m[p[6:0]]; if (we) m[p[6:0]] = wd; end
      end
      3'd4: begin
        a = bit_byte(ad);
        e_bit = m[a[6:0]][ad[2:0]];
        if (we) m[a[6:0]][ad[2:0]] = bv;
      end
      3'd5: begin
        n = e_sp + 8'd1;
        if (n > 8'h7F) e_err = 1'b1;
        else begin e_sp = n; m[n[6:0]] = wd; end
      end
      3'd6: begin
        if (e_sp > 8'h7F) begin e_err = 1'b1; e_rd = 8'h00; end
        else begin e_rd = m[e_sp[6:0]]; e_sp = e_sp - 8'd1; end
      end
      default: ;
    endcase
  endtask

  task automatic run(input string req, input logic [2:0] op, input logic we,
                     input logic [1:0] bk, input logic [2:0] rs, input logic [6:0] ad,
                     input logic ps, input logic [7:0] wd, input logic bv);
    op_i = op; we_i = we; bank_i = bk; reg_sel_i = rs; addr_i = ad;
    ptr_sel_i = ps; wr_data_i = wd; bit_val_i = bv;
    model(op, we, bk, rs, ad, ps, wd, bv);
    @(negedge clk);
    chk({req, " rd_data"}, rd_data_o, e_rd);
    chk({req, " rd_bit"}, rd_bit_o, e_bit);
    chk({req, " err"}, err_o, e_err);
    chk({req, " sp"}, sp_o, e_sp);
    op_i = 3'd0; we_i = 1'b0;
  endtask

  task automatic dir_rd(input string req, input logic [6:0] a, input logic [7:0] exp);
    run(req, 3'd2, 1'b0, 2'd0, 3'd0, a, 1'b0, 8'h00, 1'b0);
    chk({req, " byte"}, rd_data_o, exp);
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int unsigned seed = 32'h0000_51A7;
    void'($urandom(seed));
    rst_n = 1'b0; op_i = 0; we_i = 0; bank_i = 0; reg_sel_i = 0; addr_i = 0;
    ptr_sel_i = 0; wr_data_i = 0; bit_val_i = 0;
    for (int i = 0; i < 128; i++) m[i] = 8'h00;
    e_sp = 8'h07; e_rd = 8'h00; e_bit = 1'b0; e_err = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 sp", sp_o, 8'h07);
    chk("R1 rd", rd_data_o, 0);
    chk("R1 err", err_o, 0);
    dir_rd("R1", 7'h45, 8'h00);
    // R7 push order from reset
    run("R7", 3'd5, 1'b0, 0, 0, 0, 0, 8'h25, 0);
    run("R7", 3'd5, 1'b0, 0, 0, 0, 0, 8'h12, 0);
    run("R7", 3'd5, 1'b0, 0, 0, 0, 0, 8'hF3, 0);
    chk("R7 sp", sp_o, 8'h0A);
    dir_rd("R7", 7'h08, 8'h25);
    dir_rd("R7", 7'h09, 8'h12);
    dir_rd("R7", 7'h0A, 8'hF3);
    // R8 pop
    run("R8", 3'd6, 1'b0, 0, 0, 0, 0, 0, 0);
    chk("R8 popped", rd_data_o, 8'hF3);
    chk("R8 sp", sp_o, 8'h09);
    // R2 bank window
    run("R2", 3'd1, 1'b1, 2'd2, 3'd3, 0, 0, 8'hA5, 0);
    dir_rd("R2", 7'h13, 8'hA5);
    run("R2", 3'd1, 1'b1, 2'd3, 3'd7, 0, 0, 8'h3C, 0);
    dir_rd("R2", 7'h1F, 8'h3C);
    // R3 direct alias of bank 0
    run("R3", 3'd2, 1'b1, 0, 0, 7'h04, 0, 8'h77, 0);
    run("R3", 3'd1, 1'b0, 2'd0, 3'd4, 0, 0, 0, 0);
    chk("R3 alias", rd_data_o, 8'h77);
    // R10 read before write
    run("R10", 3'd2, 1'b1, 0, 0, 7'h04, 0, 8'h11, 0);
    chk("R10 old value", rd_data_o, 8'h77);
    // R4 indirect through R1 of bank 1
    run("R4", 3'd1, 1'b1, 2'd1, 3'd1, 0, 0, 8'h50, 0);
    run("R4", 3'd3, 1'b1, 2'd1, 0, 0, 1'b1, 8'h9E, 0);
    dir_rd("R4", 7'h50, 8'h9E);
    // R5/R6 bits
    run("R6", 3'd4, 1'b1, 0, 0, 7'h05, 0, 0, 1'b1);
    dir_rd("R6", 7'h20, 8'h20);
    run("R6", 3'd2, 1'b1, 0, 0, 7'h2F, 0, 8'h5A, 0);
    run("R6", 3'd4, 1'b1, 0, 0, 7'h79, 0, 0, 1'b1);
    dir_rd("R6", 7'h2F, 8'h5A);
    run("R6", 3'd4, 1'b1, 0, 0, 7'h7E, 0, 0, 1'b0);
    dir_rd("R6", 7'h2F, 8'h1A);
    run("R5", 3'd4, 1'b0, 0, 0, 7'h7C, 0, 0, 0);
    chk("R5 bit", rd_bit_o, 1);
    // R9 indirect out of range, aliased byte untouched
    run("R9", 3'd1, 1'b1, 2'd0, 3'd0, 0, 0, 8'h90, 0);
    run("R9", 3'd3, 1'b1, 2'd0, 0, 0, 1'b0, 8'hEE, 0);
    chk("R9 err", err_o, 1);
    dir_rd("R9", 7'h10, 8'h00);
    // R9 stack overflow at 0x7F
    while (e_sp < 8'h7F) run("R7", 3'd5, 1'b0, 0, 0, 0, 0, e_sp, 0);
    run("R9", 3'd5, 1'b0, 0, 0, 0, 0, 8'hCD, 0);
    chk("R9 overflow err", err_o, 1);
    chk("R9 overflow sp", sp_o, 8'h7F);
    run("R8", 3'd6, 1'b0, 0, 0, 0, 0, 0, 0);
    chk("R8 top", rd_data_o, 8'h7E);
    // random mix
    for (int k = 0; k < 3000; k++) begin
      logic [2:0] op;
      op = 3'($urandom_range(0, 6));
      run("R10 random", op, 1'($urandom), 2'($urandom), 3'($urandom),
          7'($urandom), 1'($urandom), 8'($urandom), 1'($urandom));
    end
    for (int i = 0; i < 128; i++) dir_rd("R3 sweep", 7'(i), m[i]);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule